// File: doc/BRIEF.md
# Segment Register Load and Address Translation

This block models a single segment register as a visible selector plus a hidden descriptor cache, together with the offset-to-linear address path that reads only that cache. A mode input chooses how a selector write fills the cache. In real mode the selector is turned straight into a base and a fixed 64 KB limit in one cycle. In protected mode the selector picks an 8-byte descriptor from a global or a local table. The block fetches that descriptor over a 32-bit valid/ready read port in two beats, then decodes it into a base, a byte-exact limit, an access byte and a flag nibble.

Translation requests add an offset to the cached base and compare the offset with the cached effective limit. The result comes back one cycle later as either a valid linear address or a one-cycle fault pulse. Neither the selector value nor the current mode affects translation once the cache has been written. A segment filled in real mode therefore keeps its 16-bit shape after protected mode is turned on, until software writes the selector again.

Top module: `seg_cache_unit`

## Requirements
- R1: After reset the cache holds base 0, effective limit 0x0000FFFF, access byte 0 and flags 0; the visible selector is 0 and busy is low.
- R2: With the mode input low, a selector write sets the cached base to the selector shifted left by 4, the limit to 0xFFFF and the flags to 0 (D/B, bit 2 of the flag output, clear). This is visible on the next cycle, with no memory read.
- R3: A translation in a segment whose limit is 0xFFFF faults when the offset is above 0xFFFF.
- R4: With the mode input high, selector bits 15:3 are the index, bit 2 chooses the local table when 1 and the global table when 0, and bits 1:0 (requested privilege) are kept in the visible selector. The block reads the words at table base + index*8 and then +4.
- R5: The low descriptor word carries limit 15:0 in bits 15:0 and base 15:0 in bits 31:16. The high word carries base 23:16 in bits 7:0, the access byte in bits 15:8, limit 19:16 in bits 19:16, the flags in bits 23:20 (G = bit 3, D/B = bit 2) and base 31:24 in bits 31:24.
- R6: With G set, the effective limit is the 20-bit limit times 4096 plus 4095, so an all-ones limit covers the whole 4 GB space. With G clear, the effective limit is the 20-bit limit in bytes.
- R7: Loading global index 0 completes without fault, but every translation through that segment faults.
- R8: If index*8+7 exceeds the selected table's limit, no memory read is made, a load-fault pulse lasts one cycle, and both the cache and the visible selector keep their old values.
- R9: A translation request returns, one cycle later, either a valid strobe with base + offset or a fault pulse, never both.
- R10: Busy rises on a protected-mode selector write and stays high until the cache is updated. Selector writes made while busy are ignored.
- R11: Translation uses only the cache. A segment loaded in real mode keeps its base and clear D/B after the mode input goes high, until it is reloaded.
- R12: A translation requested in the cycle the cache is being written uses the old cached values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pe_i | input | 1 | Mode: 1 protected, 0 real |
| sel_we_i | input | 1 | Selector write strobe |
| sel_i | input | 16 | Selector value written |
| gtab_base_i | input | 32 | Global table base address |
| gtab_lim_i | input | 16 | Global table limit in bytes |
| ltab_base_i | input | 32 | Local table base address |
| ltab_lim_i | input | 16 | Local table limit in bytes |
| mem_valid_o | output | 1 | Descriptor read request |
| mem_addr_o | output | 32 | Descriptor read address |
| mem_ready_i | input | 1 | Read accepted, data present |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Descriptor fetch in progress |
| ld_fault_o | output | 1 | Selector load fault pulse |
| sel_o | output | 16 | Visible selector |
| seg_base_o | output | 32 | Cached base |
| seg_lim_o | output | 32 | Cached effective limit |
| seg_attr_o | output | 8 | Cached access byte |
| seg_flags_o | output | 4 | Cached flag nibble |
| xl_valid_i | input | 1 | Translation request |
| xl_off_i | input | 32 | Offset to translate |
| lin_valid_o | output | 1 | Linear address valid |
| lin_addr_o | output | 32 | Linear address |
| xl_fault_o | output | 1 | Translation fault pulse |

## Verification
A translation request and the final write into the descriptor cache can fall into the same cycle, because translation keeps running while a fetch is still in progress. The bench reloads the register with a selector whose base differs from the current one. It counts the beats of the read port and raises a translation request in the cycle the high word is accepted. The linear address that comes back must be built from the old base, while the base output on the following cycle already shows the new one.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int AW = 32;
    localparam int SW = 16;

    typedef enum logic [1:0] {FS_IDLE, FS_LO, FS_HI} fetch_st_t;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] lim;
        logic [7:0]    attr;
        logic [3:0]    flags;
        logic          nul;
    } seg_cache_t;

    typedef struct packed {
        fetch_st_t     st;
        logic [AW-1:0] addr;
        logic [31:0]   lo;
        logic [SW-1:0] pend;
        logic [SW-1:0] sel;
        seg_cache_t    cache;
        logic          ld_fault;
    } ctl_t;
endpackage

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
    import seg_pkg::*;
#(
    parameter int PAGE_SHIFT = 12
) (
    input  logic [31:0] lo_i,
    input  logic [31:0] hi_i,
    output seg_cache_t  dec_o
);
    localparam logic [AW-1:0] PAGE_FILL = (AW'(1) << PAGE_SHIFT) - AW'(1);

    logic [19:0] raw_lim;

    always_comb begin
        raw_lim           = {hi_i[19:16], lo_i[15:0]};
        dec_o.base        = {hi_i[31:24], hi_i[7:0], lo_i[31:16]};
        dec_o.attr        = hi_i[15:8];
        dec_o.flags       = hi_i[23:20];
        dec_o.nul         = 1'b0;
        if (hi_i[23]) begin
            dec_o.lim = (AW'(raw_lim) << PAGE_SHIFT) | PAGE_FILL;
        end else begin
            dec_o.lim = AW'(raw_lim);
        end
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xl_valid_i,
    input  logic [AW-1:0] xl_off_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] lim_i,
    input  logic          nul_i,
    output logic          lin_valid_o,
    output logic [AW-1:0] lin_addr_o,
    output logic          xl_fault_o
);
    typedef struct packed {
        logic          ok;
        logic          flt;
        logic [AW-1:0] lin;
    } xl_t;

    xl_t x_d, x_q;

    always_comb begin
        x_d     = x_q;
        x_d.ok  = 1'b0;
        x_d.flt = 1'b0;
        if (xl_valid_i) begin
            if (nul_i || (xl_off_i > lim_i)) begin
                x_d.flt = 1'b1;
            end else begin
                x_d.ok  = 1'b1;
                x_d.lin = base_i + xl_off_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) x_q <= '0;
        else        x_q <= x_d;
    end

    assign lin_valid_o = x_q.ok;
    assign lin_addr_o  = x_q.lin;
    assign xl_fault_o  = x_q.flt;

    AST_XL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(lin_valid_o && xl_fault_o)); // R9
    AST_XL_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        (lin_valid_o || xl_fault_o) |-> $past(xl_valid_i)); // R9
    AST_NULL_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_valid_i && nul_i) |=> xl_fault_o); // R7
endmodule

// File: rtl/seg_cache_unit.sv
module seg_cache_unit
    import seg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pe_i,
    input  logic          sel_we_i,
    input  logic [15:0]   sel_i,
    input  logic [31:0]   gtab_base_i,
    input  logic [15:0]   gtab_lim_i,
    input  logic [31:0]   ltab_base_i,
    input  logic [15:0]   ltab_lim_i,
    output logic          mem_valid_o,
    output logic [31:0]   mem_addr_o,
    input  logic          mem_ready_i,
    input  logic [31:0]   mem_rdata_i,
    output logic          busy_o,
    output logic          ld_fault_o,
    output logic [15:0]   sel_o,
    output logic [31:0]   seg_base_o,
    output logic [31:0]   seg_lim_o,
    output logic [7:0]    seg_attr_o,
    output logic [3:0]    seg_flags_o,
    input  logic          xl_valid_i,
    input  logic [31:0]   xl_off_i,
    output logic          lin_valid_o,
    output logic [31:0]   lin_addr_o,
    output logic          xl_fault_o
);
    localparam int RM_SHIFT = 4;
    localparam logic [AW-1:0] RM_LIMIT = AW'(16'hFFFF);
    localparam int DESC_SHIFT = 3;

    ctl_t       r_d, r_q;
    seg_cache_t dec;
    logic [AW-1:0] tbl_base, tbl_lim, ent_off, ent_end;

    seg_desc_decode #(.PAGE_SHIFT(12)) u_dec (
        .lo_i (r_q.lo),
        .hi_i (mem_rdata_i),
        .dec_o(dec)
    );

    always_comb begin
        r_d          = r_q;
        r_d.ld_fault = 1'b0;
        tbl_base     = sel_i[2] ? ltab_base_i : gtab_base_i;
        tbl_lim      = AW'(sel_i[2] ? ltab_lim_i : gtab_lim_i);
        ent_off      = AW'(sel_i[SW-1:DESC_SHIFT]) << DESC_SHIFT;
        ent_end      = ent_off + AW'(7);
        unique case (r_q.st)
            FS_IDLE: begin
                if (sel_we_i && !pe_i) begin
                    r_d.sel         = sel_i;
                    r_d.cache.base  = AW'(sel_i) << RM_SHIFT;
                    r_d.cache.lim   = RM_LIMIT;
                    r_d.cache.attr  = '0;
                    r_d.cache.flags = '0;
                    r_d.cache.nul   = 1'b0;
                end else if (sel_we_i) begin
                    if (ent_end > tbl_lim) begin
                        r_d.ld_fault = 1'b1;
                    end else begin
                        r_d.pend = sel_i;
                        r_d.addr = tbl_base + ent_off;
                        r_d.st   = FS_LO;
                    end
                end
            end
            FS_LO: begin
                if (mem_ready_i) begin
                    r_d.lo   = mem_rdata_i;
                    r_d.addr = r_q.addr + AW'(4);
                    r_d.st   = FS_HI;
                end
            end
            FS_HI: begin
                if (mem_ready_i) begin
                    r_d.cache     = dec;
                    r_d.cache.nul = (r_q.pend[SW-1:2] == '0);
                    r_d.sel       = r_q.pend;
                    r_d.st        = FS_IDLE;
                end
            end
            default: r_d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.st        <= FS_IDLE;
            r_q.cache.lim <= RM_LIMIT;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_valid_o = (r_q.st != FS_IDLE);
    assign mem_addr_o  = r_q.addr;
    assign busy_o      = (r_q.st != FS_IDLE);
    assign ld_fault_o  = r_q.ld_fault;
    assign sel_o       = r_q.sel;
    assign seg_base_o  = r_q.cache.base;
    assign seg_lim_o   = r_q.cache.lim;
    assign seg_attr_o  = r_q.cache.attr;
    assign seg_flags_o = r_q.cache.flags;

    seg_xlate u_xl (
        .clk        (clk),
        .rst_n      (rst_n),
        .xl_valid_i (xl_valid_i),
        .xl_off_i   (xl_off_i),
        .base_i     (r_q.cache.base),
        .lim_i      (r_q.cache.lim),
        .nul_i      (r_q.cache.nul),
        .lin_valid_o(lin_valid_o),
        .lin_addr_o (lin_addr_o),
        .xl_fault_o (xl_fault_o)
    );

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o))); // R4
    AST_LDF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fault_o |-> ($stable(sel_o) && $stable(seg_base_o) && !busy_o)); // R8
    AST_LDF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fault_o |=> !ld_fault_o); // R8
    AST_BUSY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !mem_ready_i) |=> busy_o); // R10
    AST_SEL_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(sel_o)); // R10
endmodule

// File: tb/seg_cache_unit_test.sv
module seg_cache_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pe = 1'b0, sel_we = 1'b0, xl_valid = 1'b0;
    logic [15:0] sel = '0;
    logic [31:0] off = '0;
    logic        mem_valid, busy, ld_fault, lin_valid, xl_fault;
    logic [31:0] mem_addr, mem_rdata, seg_base, seg_lim, lin_addr;
    logic [15:0] sel_q;
    logic [7:0]  seg_attr;
    logic [3:0]  seg_flags;
    int checks = 0, errors = 0, nreads = 0;
    logic [31:0] rlog [4];

    always #10 clk = ~clk;

    function automatic logic [31:0] memword(input logic [31:0] a);
        case (a)
            32'h1008: return 32'h0000FFFF;
            32'h100C: return 32'h00CF9A00;
            32'h1010: return 32'h0000FFFF;
            32'h1014: return 32'h00CF9200;
            32'h2008: return 32'h00000010;
            32'h200C: return 32'h00409212;
            default:  return 32'h0;
        endcase
    endfunction
    assign mem_rdata = memword(mem_addr);

    always @(posedge clk) if (mem_valid) begin
        if (nreads < 4) rlog[nreads] <= mem_addr;
        nreads <= nreads + 1;
    end

    seg_cache_unit uut (
        .clk(clk), .rst_n(rst_n), .pe_i(pe), .sel_we_i(sel_we), .sel_i(sel),
        .gtab_base_i(32'h1000), .gtab_lim_i(16'h0017),
        .ltab_base_i(32'h2000), .ltab_lim_i(16'h000F),
        .mem_valid_o(mem_valid), .mem_addr_o(mem_addr), .mem_ready_i(mem_valid),
        .mem_rdata_i(mem_rdata), .busy_o(busy), .ld_fault_o(ld_fault),
        .sel_o(sel_q), .seg_base_o(seg_base), .seg_lim_o(seg_lim),
        .seg_attr_o(seg_attr), .seg_flags_o(seg_flags),
        .xl_valid_i(xl_valid), .xl_off_i(off), .lin_valid_o(lin_valid),
        .lin_addr_o(lin_addr), .xl_fault_o(xl_fault)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] s);
        sel = s; sel_we = 1'b1;
        @(negedge clk); sel_we = 1'b0;
        for (int i = 0; i < 20 && busy; i++) @(negedge clk);
    endtask

    task automatic xlate(input logic [31:0] o);
        off = o; xl_valid = 1'b1;
        @(negedge clk); xl_valid = 1'b0;
    endtask

    // {pe, selector, offset, fault, linear}
    localparam logic [81:0] VEC [9] = '{
        {1'b0, 16'h1234, 32'h00000010, 1'b0, 32'h00012350}, // R2
        {1'b0, 16'hFFFF, 32'h0000FFFF, 1'b0, 32'h0010FFEF}, // R2
        {1'b0, 16'h0100, 32'h00010000, 1'b1, 32'h0},        // R3
        {1'b1, 16'h0008, 32'hFFFFFFFF, 1'b0, 32'hFFFFFFFF}, // R6
        {1'b1, 16'h0013, 32'h00400000, 1'b0, 32'h00400000}, // R4
        {1'b1, 16'h0000, 32'h00000000, 1'b1, 32'h0},        // R7
        {1'b1, 16'h0003, 32'h00000004, 1'b1, 32'h0},        // R7
        {1'b1, 16'h000C, 32'h00000010, 1'b0, 32'h00120010}, // R6
        {1'b1, 16'h000C, 32'h00000011, 1'b1, 32'h0}         // R6
    };

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 base", seg_base, 32'h0);
        chk("R1 lim", seg_lim, 32'h0000FFFF);
        chk("R1 sel", {16'h0, sel_q}, 32'h0);
        chk("R1 busy", {31'h0, busy}, 32'h0);
        chk("R1 flags", {28'h0, seg_flags}, 32'h0);

        foreach (VEC[k]) begin
            pe = VEC[k][81];
            load(VEC[k][80:65]);
            xlate(VEC[k][64:33]);
            chk($sformatf("R9 vec%0d fault", k), {31'h0, xl_fault}, {31'h0, VEC[k][32]});
            chk($sformatf("R9 vec%0d valid", k), {31'h0, lin_valid}, {31'h0, ~VEC[k][32]});
            if (!VEC[k][32]) chk($sformatf("R9 vec%0d lin", k), lin_addr, VEC[k][31:0]);
        end

        // R4 read addresses for local-table index 1, privilege kept
        pe = 1'b1; nreads = 0;
        @(negedge clk);
        load(16'h000E);
        chk("R4 first read", rlog[0], 32'h2008);
        chk("R4 second read", rlog[1], 32'h200C);
        chk("R4 sel rpl", {16'h0, sel_q}, 32'h000E);
        chk("R6 byte limit", seg_lim, 32'h10);

        // R5 decode of code descriptor
        load(16'h0008);
        chk("R5 attr", {24'h0, seg_attr}, 32'h9A);
        chk("R5 flags", {28'h0, seg_flags}, 32'hC);
        chk("R5 base", seg_base, 32'h0);
        chk("R6 flat limit", seg_lim, 32'hFFFFFFFF);

        // R8 global index 3 beyond table limit 0x17
        nreads = 0;
        @(negedge clk);
        sel = 16'h0018; sel_we = 1'b1;
        @(negedge clk); sel_we = 1'b0;
        chk("R8 pulse", {31'h0, ld_fault}, 32'h1);
        chk("R8 busy", {31'h0, busy}, 32'h0);
        chk("R8 sel", {16'h0, sel_q}, 32'h0008);
        chk("R8 attr", {24'h0, seg_attr}, 32'h9A);
        @(negedge clk);
        chk("R8 one cycle", {31'h0, ld_fault}, 32'h0);
        chk("R8 no read", nreads, 32'h0);
        // R8 local index 2 beyond local limit 0x0F
        load(16'h0014);
        chk("R8 local kept", {16'h0, sel_q}, 32'h0008);

        // R10 busy and ignored write
        sel = 16'h0010; sel_we = 1'b1;
        @(negedge clk);
        chk("R10 busy", {31'h0, busy}, 32'h1);
        sel = 16'h000C;
        @(negedge clk); sel_we = 1'b0;
        chk("R10 busy hold", {31'h0, busy}, 32'h1);
        @(negedge clk);
        chk("R10 done", {31'h0, busy}, 32'h0);
        chk("R10 ignored", {16'h0, sel_q}, 32'h0010);
        chk("R10 data attr", {24'h0, seg_attr}, 32'h92);

        // R11 real-mode segment survives switch to protected mode
        pe = 1'b0;
        load(16'h2000);
        pe = 1'b1;
        @(negedge clk);
        xlate(32'h5);
        chk("R11 lin", lin_addr, 32'h00020005);
        chk("R11 db clear", {31'h0, seg_flags[2]}, 32'h0);
        xlate(32'h10000);
        chk("R11 limit kept", {31'h0, xl_fault}, 32'h1);

        // R12 translation in the completion cycle sees the old base
        load(16'h000C);
        sel = 16'h0008; sel_we = 1'b1;
        @(negedge clk); sel_we = 1'b0;
        @(negedge clk);
        off = 32'h4; xl_valid = 1'b1;
        @(negedge clk); xl_valid = 1'b0;
        chk("R12 old base used", lin_addr, 32'h00120004);
        chk("R12 cache new", seg_base, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule